// File: doc/BRIEF.md
# Indirect-Window SPI Follow-Mode Bridge

This block lets a host reach a serial flash through a tiny byte-wide I/O window. Four window locations form a 32-bit address (least significant byte at the lowest offset), and one further location is a data port. Every host access to the data port becomes a memory-style cycle to the assembled address, and the page that address falls in decides what happens on the SPI pins: one page deselects the flash, another page clocks a byte out (host write) or in (host read) with chip select held low.

A complete flash transaction is therefore a deselect write, a run of byte writes to the select page, a run of byte reads from the same page, and a final deselect write. Chip select stays low between bytes for as long as the host keeps touching the select page. The SPI side runs in mode 0, most significant bit first, with SCLK at the system clock divided by twice the `CLK_DIV` parameter. Data-port accesses that shift a byte stall the host with `host_ready` low until the eighth bit is done; every other access completes in the cycle it is presented.

Top module: `spi_follow_bridge`

## Requirements
- R1: After synchronous reset, spi_cs_n is 1, spi_sclk is 0 and the address window holds 0xFFFFF000 (offset 0 reads 0x00, offset 1 reads 0xF0, offsets 2 and 3 read 0xFF).
- R2: Offsets 0 to 3 are address bytes, offset 0 least significant; a write updates only its own byte, a read returns it, and both complete with host_ready high in the cycle the strobe is presented.
- R3: A host write to offset 4 while the address lies in page 0xFFFFFE00..0xFFFFFEFF drives spi_cs_n high whatever the data value, produces no SCLK pulse and completes at once.
- R4: A host write to offset 4 while the address lies in page 0xFFFFFD00..0xFFFFFDFF (any low address byte) drives spi_cs_n low and sends the data byte MSB first in mode 0: eight SCLK pulses, MOSI changing only while SCLK is low.
- R5: A host read of offset 4 in page 0xFFFFFDxx drives spi_cs_n low, holds MOSI at 1 for all eight bits, samples MISO on each rising SCLK edge MSB first and returns that byte on host_rdata.
- R6: A shifting data-port access holds host_ready low from the strobe until the byte is complete, then raises it for one cycle with read data valid; with divider D the strobe sees host_ready low on exactly 16*D+1 cycles.
- R7: Data-port accesses to any other address, and reads of the 0xFFFFFExx page, are ignored: they complete at once, leave spi_cs_n unchanged, produce no SCLK pulse, and reads return 0xFF.
- R8: Offsets 5 to 7 are unused: writes change neither the address nor the SPI pins, reads return 0xFF, and both complete at once.
- R9: spi_cs_n stays low across successive select-page byte writes and reads and rises only on a deselect write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe, held until host_ready |
| host_rd | input | 1 | Host read strobe, held until host_ready |
| host_off | input | 3 | Window offset: 0-3 address bytes, 4 data port |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid while host_ready is high |
| host_ready | output | 1 | Access completes at the clock edge where this is high |
| spi_sclk | output | 1 | SPI serial clock, idles low |
| spi_mosi | output | 1 | SPI data to the flash |
| spi_miso | input | 1 | SPI data from the flash |
| spi_cs_n | output | 1 | SPI chip select, active low |

## Verification
The two functions that meet in one cycle are the completion of a stalled shift and the address/chip-select decode of the host's next access: the final falling SCLK edge, the single-cycle ready pulse and the state's return to idle all coincide, and a strobe still held at that edge must not start a second transfer. The bench provokes this by keeping the strobe up through the completing edge and issuing the next select-page access immediately after, then judges it by counting rising SCLK edges per access (exactly eight), the stall length and that chip select never bounces between bytes. A second coincidence, a deselect write arriving right after a read, is judged by chip select rising with no extra SCLK edge.

// File: rtl/spi_follow_pkg.sv
// Package: shared types for the follow-mode bridge.
// Assumes byte-wide host data and a page selected by address bits above the low byte.
package spi_follow_pkg;

    localparam int BYTE_W = 8;

    // Kind of SPI action a data-port access decodes to.
    typedef enum logic [1:0] {
        ACC_NONE     = 2'd0,
        ACC_DESELECT = 2'd1,
        ACC_SEND     = 2'd2,
        ACC_RECV     = 2'd3
    } acc_kind_e;

    // Bridge control state.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } brg_state_e;

    // True when the kind needs a byte shifted on the serial pins.
    function automatic logic kind_shifts(acc_kind_e k);
        return (k == ACC_SEND) || (k == ACC_RECV);
    endfunction

endpackage

// File: rtl/addr_window.sv
// Module: addr_window
// Holds the little-endian address bytes of the indirect window.
// Assumes the caller qualifies the write enable; index 0 is the least significant byte.
module addr_window #(
    parameter int          NBYTES     = 4,
    parameter logic [31:0] RESET_ADDR = 32'hFFFF_F000,
    localparam int         IDX_W      = (NBYTES > 1) ? $clog2(NBYTES) : 1,
    localparam int         AW         = NBYTES * spi_follow_pkg::BYTE_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we,
    input  logic [IDX_W-1:0]                  idx,
    input  logic [spi_follow_pkg::BYTE_W-1:0] wdata,
    output logic [spi_follow_pkg::BYTE_W-1:0] rbyte,
    output logic [AW-1:0]                     addr
);
    import spi_follow_pkg::*;

    logic [NBYTES-1:0][BYTE_W-1:0] bytes_q;

    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        // Purpose: load one address byte when its index is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bytes_q[g] <= RESET_ADDR[g*BYTE_W +: BYTE_W];
            end else if (we && (idx == IDX_W'(g))) begin
                bytes_q[g] <= wdata;
            end
        end
        assign addr[g*BYTE_W +: BYTE_W] = bytes_q[g];
    end

    // Purpose: return the selected byte for host reads.
    always_comb begin
        rbyte = bytes_q[idx];
    end

endmodule

// File: rtl/page_decoder.sv
// Module: page_decoder
// Classifies a data-port access by the page of the assembled address.
// Assumes a write strobe wins if both strobes are presented together.
module page_decoder #(
    parameter int              AW      = 32,
    parameter logic [AW-9:0]   HI_PAGE = 24'hFFFFFE,
    parameter logic [AW-9:0]   LO_PAGE = 24'hFFFFFD
) (
    input  logic                       is_wr,
    input  logic                       is_rd,
    input  logic [AW-1:0]              addr,
    output spi_follow_pkg::acc_kind_e  kind
);
    import spi_follow_pkg::*;

    logic [AW-9:0] page;
    assign page = addr[AW-1:8];

    // Purpose: map strobe direction and page to an SPI action.
    always_comb begin
        kind = ACC_NONE;
        if (is_wr) begin
            if (page == HI_PAGE)      kind = ACC_DESELECT;
            else if (page == LO_PAGE) kind = ACC_SEND;
        end else if (is_rd) begin
            if (page == LO_PAGE)      kind = ACC_RECV;
        end
    end

endmodule

// File: rtl/spi_byte_engine.sv
// Module: spi_byte_engine
// Shifts one byte in SPI mode 0, MSB first; each SCLK half lasts DIV clocks.
// Assumes start is only honoured while idle; done pulses one cycle after the last fall.
module spi_byte_engine #(
    parameter int DIV = 2,
    localparam int BW    = spi_follow_pkg::BYTE_W,
    localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1,
    localparam int HW    = $clog2(2 * BW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [BW-1:0] tx_byte,
    input  logic          miso,
    output logic          busy,
    output logic          done,
    output logic [BW-1:0] rx_byte,
    output logic          sclk,
    output logic          mosi
);
    logic [DIV_W-1:0] div_q;
    logic [HW-1:0]    half_q;
    logic [BW-1:0]    tx_q;

    // Purpose: divider, half-period counter, shift registers and SCLK.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            div_q   <= '0;
            half_q  <= '0;
            tx_q    <= '1;
            rx_byte <= '0;
            sclk    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy   <= 1'b1;
                tx_q   <= tx_byte;
                div_q  <= '0;
                half_q <= '0;
                sclk   <= 1'b0;
            end else if (busy) begin
                if (div_q == DIV_W'(DIV - 1)) begin
                    div_q  <= '0;
                    half_q <= half_q + 1'b1;
                    if (!sclk) begin
                        sclk    <= 1'b1;
                        rx_byte <= {rx_byte[BW-2:0], miso};
                    end else begin
                        sclk <= 1'b0;
                        tx_q <= {tx_q[BW-2:0], 1'b1};
                    end
                    if (half_q == HW'(2 * BW - 1)) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end
        end
    end

    assign mosi = tx_q[BW-1];

endmodule

// File: rtl/spi_follow_bridge.sv
// Module: spi_follow_bridge (top)
// Host byte window whose data-port accesses become SPI follow-mode cycles.
// Assumes the host holds a strobe until host_ready and never presents both strobes.
module spi_follow_bridge #(
    parameter int          CLK_DIV    = 2,
    parameter int          OFF_W      = 3,
    parameter int          ADDR_BYTES = 4,
    parameter logic [31:0] RESET_ADDR = 32'hFFFF_F000,
    parameter logic [23:0] HI_PAGE    = 24'hFFFFFE,
    parameter logic [23:0] LO_PAGE    = 24'hFFFFFD,
    localparam int         BW         = spi_follow_pkg::BYTE_W,
    localparam int         AW         = ADDR_BYTES * BW,
    localparam int         IDX_W      = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [OFF_W-1:0] host_off,
    input  logic [BW-1:0]    host_wdata,
    output logic [BW-1:0]    host_rdata,
    output logic             host_ready,
    output logic             spi_sclk,
    output logic             spi_mosi,
    input  logic             spi_miso,
    output logic             spi_cs_n
);
    import spi_follow_pkg::*;

    localparam logic [OFF_W-1:0] DATA_OFF = OFF_W'(ADDR_BYTES);

    brg_state_e    state_q;
    acc_kind_e     kind;
    logic          acc, addr_sel, data_sel, idle;
    logic          win_we, eng_start, eng_busy, eng_done;
    logic [BW-1:0] win_rbyte, eng_rx, eng_tx;
    logic [AW-1:0] win_addr;

    assign acc      = host_wr || host_rd;
    assign addr_sel = host_off < OFF_W'(ADDR_BYTES);
    assign data_sel = host_off == DATA_OFF;
    assign idle     = state_q == ST_IDLE;
    assign win_we   = idle && host_wr && addr_sel;

    addr_window #(
        .NBYTES     (ADDR_BYTES),
        .RESET_ADDR (RESET_ADDR)
    ) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (win_we),
        .idx   (host_off[IDX_W-1:0]),
        .wdata (host_wdata),
        .rbyte (win_rbyte),
        .addr  (win_addr)
    );

    page_decoder #(
        .AW      (AW),
        .HI_PAGE (HI_PAGE[AW-9:0]),
        .LO_PAGE (LO_PAGE[AW-9:0])
    ) u_dec (
        .is_wr (host_wr && data_sel),
        .is_rd (host_rd && data_sel),
        .addr  (win_addr),
        .kind  (kind)
    );

    assign eng_start = idle && kind_shifts(kind);
    assign eng_tx    = (kind == ACC_SEND) ? host_wdata : '1;

    spi_byte_engine #(
        .DIV (CLK_DIV)
    ) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (eng_start),
        .tx_byte (eng_tx),
        .miso    (spi_miso),
        .busy    (eng_busy),
        .done    (eng_done),
        .rx_byte (eng_rx),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi)
    );

    // Purpose: track whether a byte transfer is outstanding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (idle) begin
            if (eng_start) state_q <= ST_XFER;
        end else if (eng_done) begin
            state_q <= ST_IDLE;
        end
    end

    // Purpose: chip select follows the page of each accepted data-port access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spi_cs_n <= 1'b1;
        end else if (idle) begin
            if (kind == ACC_DESELECT)   spi_cs_n <= 1'b1;
            else if (kind_shifts(kind)) spi_cs_n <= 1'b0;
        end
    end

    // Purpose: completion handshake; only shifting accesses stall.
    always_comb begin
        if (!idle)              host_ready = eng_done;
        else if (eng_start)     host_ready = 1'b0;
        else                    host_ready = acc;
    end

    // Purpose: read data mux for address bytes, received byte or idle value.
    always_comb begin
        if (addr_sel)                 host_rdata = win_rbyte;
        else if (data_sel && !idle)   host_rdata = eng_rx;
        else                          host_rdata = '1;
    end

endmodule

// File: rtl/spi_follow_bridge_chk.sv
// Module: spi_follow_bridge_chk
// Port-level temporal checks for the bridge, bound into every instance.
module spi_follow_bridge_chk #(
    parameter int OFF_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_wr,
    input logic             host_rd,
    input logic [OFF_W-1:0] host_off,
    input logic             host_ready,
    input logic             spi_sclk,
    input logic             spi_mosi,
    input logic             spi_cs_n
);
    // R1: reset leaves the flash deselected with SCLK low.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (spi_cs_n && !spi_sclk));

    // R4: SCLK only pulses while the flash is selected.
    a_r4_sclk_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> !spi_cs_n);

    // R4: MOSI holds still while SCLK stays high (mode 0).
    a_r4_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

    // R6: the host is never released mid-byte.
    a_r6_stall_while_clocking: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> !host_ready);

    // R2, R8: non-data-port accesses never stall.
    a_r2_window_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        ((host_wr || host_rd) && (host_off != OFF_W'(4))) |-> host_ready);

    // R9: chip select moves only after a data-port access was presented.
    a_r9_cs_by_data_port: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(spi_cs_n) |-> $past((host_wr || host_rd) && (host_off == OFF_W'(4))));

endmodule

bind spi_follow_bridge spi_follow_bridge_chk #(.OFF_W(OFF_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_off   (host_off),
    .host_ready (host_ready),
    .spi_sclk   (spi_sclk),
    .spi_mosi   (spi_mosi),
    .spi_cs_n   (spi_cs_n)
);

// File: tb/tb_spi_follow_bridge.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_spi_follow_bridge;
    localparam int DIV = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [2:0] host_off = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       host_ready;
    logic       spi_sclk, spi_mosi, spi_miso, spi_cs_n;

    int n_checks = 0;
    int n_fail   = 0;

    // Flash model state: rising edge count and captured MOSI.
    int         rises = 0;
    logic [7:0] mosi_cap = '0;
    logic [7:0] reply = 8'h00;

    always #2.5 clk = ~clk;   // 200 MHz

    spi_follow_bridge #(.CLK_DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_off(host_off), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_ready(host_ready), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    always @(posedge spi_sclk) begin
        rises    <= rises + 1;
        mosi_cap <= {mosi_cap[6:0], spi_mosi};
    end
    assign spi_miso = reply[7 - (rises % 8)];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One host access; returns read data and the number of stalled cycles.
    task automatic access(input bit wr, input logic [2:0] off, input logic [7:0] wd,
                          output logic [7:0] rd, output int stall);
        @(posedge clk); #1;
        host_wr = wr; host_rd = !wr; host_off = off; host_wdata = wd;
        stall = 0;
        forever begin
            @(negedge clk);
            if (host_ready) break;
            stall++;
            if (stall > 1000) break;
        end
        rd = host_rdata;
        @(posedge clk); #1;
        host_wr = 1'b0; host_rd = 1'b0;
    endtask

    task automatic set_addr(input logic [31:0] a);
        logic [7:0] rd; int st;
        for (int i = 0; i < 4; i++) access(1'b1, 3'(i), a[i*8 +: 8], rd, st);
    endtask

    task automatic t_reset;
        logic [7:0] rd; int st;
        logic [31:0] exp_a = 32'hFFFF_F000;
        check(spi_cs_n == 1'b1, "R1 cs_n", spi_cs_n, 1);
        check(spi_sclk == 1'b0, "R1 sclk", spi_sclk, 0);
        for (int i = 0; i < 4; i++) begin
            access(1'b0, 3'(i), 8'h00, rd, st);
            check(rd == exp_a[i*8 +: 8], "R1 addr byte", rd, exp_a[i*8 +: 8]);
        end
    endtask

    task automatic t_window;
        logic [7:0] rd; int st;
        access(1'b1, 3'd0, 8'h5A, rd, st);
        check(st == 0, "R2 write stall", st, 0);
        access(1'b0, 3'd0, 8'h00, rd, st);
        check(rd == 8'h5A && st == 0, "R2 readback byte0", rd, 8'h5A);
        access(1'b0, 3'd1, 8'h00, rd, st);
        check(rd == 8'hF0, "R2 byte1 untouched", rd, 8'hF0);
    endtask

    task automatic t_ignored_page;
        logic [7:0] rd; int st; int r0 = rises;
        set_addr(32'h1234_5600);
        access(1'b1, 3'd4, 8'h99, rd, st);
        check(st == 0 && rises == r0, "R7 write other page", rises - r0, 0);
        check(spi_cs_n == 1'b1, "R7 cs_n unchanged", spi_cs_n, 1);
        access(1'b0, 3'd4, 8'h00, rd, st);
        check(rd == 8'hFF && st == 0, "R7 read other page", rd, 8'hFF);
    endtask

    task automatic t_unused_offsets;
        logic [7:0] rd; int st; int r0 = rises;
        set_addr(32'hFFFF_FD00);
        for (int o = 5; o < 8; o++) begin
            access(1'b1, 3'(o), 8'h00, rd, st);
            access(1'b0, 3'(o), 8'h00, rd, st);
            check(rd == 8'hFF && st == 0, "R8 unused read", rd, 8'hFF);
        end
        access(1'b0, 3'd1, 8'h00, rd, st);
        check(rd == 8'hFD, "R8 address kept", rd, 8'hFD);
        check(spi_cs_n == 1'b1 && rises == r0, "R8 no spi activity", rises - r0, 0);
    endtask

    task automatic t_send(input logic [7:0] b);
        logic [7:0] rd; int st; int r0 = rises;
        access(1'b1, 3'd4, b, rd, st);
        check(rises - r0 == 8, "R4 sclk pulses", rises - r0, 8);
        check(mosi_cap == b, "R4 mosi byte", mosi_cap, b);
        check(spi_cs_n == 1'b0, "R9 cs_n low after send", spi_cs_n, 0);
        check(st == 16 * DIV + 1, "R6 stall cycles", st, 16 * DIV + 1);
    endtask

    task automatic t_recv(input logic [7:0] b);
        logic [7:0] rd; int st; int r0 = rises;
        reply = b;
        access(1'b0, 3'd4, 8'h00, rd, st);
        check(rd == b, "R5 read data", rd, b);
        check(mosi_cap == 8'hFF, "R5 mosi idle ones", mosi_cap, 8'hFF);
        check(rises - r0 == 8 && spi_cs_n == 1'b0, "R9 cs_n low after recv", rises - r0, 8);
    endtask

    task automatic t_deselect(input logic [7:0] d);
        logic [7:0] rd; int st; int r0 = rises;
        set_addr(32'hFFFF_FE00);
        access(1'b0, 3'd4, 8'h00, rd, st);
        check(rd == 8'hFF && spi_cs_n == 1'b0, "R7 read deselect page ignored", rd, 8'hFF);
        access(1'b1, 3'd4, d, rd, st);
        check(spi_cs_n == 1'b1 && st == 0, "R3 cs_n high", spi_cs_n, 1);
        check(rises == r0, "R3 no sclk", rises - r0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_window();
        t_ignored_page();
        t_unused_offsets();
        t_send(8'hA5);
        t_send(8'h3C);
        t_recv(8'hC3);
        t_recv(8'h81);
        t_deselect(8'h00);
        set_addr(32'hFFFF_FD77);
        t_send(8'h6E);
        t_recv(8'h0F);
        t_deselect(8'hFF);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule